// File: doc/BRIEF.md
# Asynchronous One-Bit DRAM Emulator

A synthesizable stand-in for a one-bit-wide asynchronous dynamic RAM without page mode. The controller under test drives a shared address bus that carries the row while the active-low row strobe falls and the column while the active-low column strobe falls. It also drives an active-low write strobe and a data input bit. The emulator returns one data bit together with an output-enable flag, which marks when a real part would drive its output pin. The strobes are not used as clocks. A fast system clock samples them, and every edge is found by comparing two registered copies, so the whole model stays in one clock domain.

The cycle type follows from the order of the strobes. A column strobe with the write strobe high is a read. A column strobe with the write strobe already low is an early write: data is taken at the column edge and the output never turns on. A write strobe that falls while the column strobe is low is a late write, which also covers read-modify-write: data is taken at the write edge and the output behaves as in a read. A column strobe that is already low when the row strobe falls starts a refresh-only cycle, and the row comes from an internal counter. The model also keeps an age for each row. Any row-strobe activation resets the age of the row it selects, and a sticky flag reports that some row went unrefreshed for too long.

Top module: `async_dram_emu`

## Requirements
- R1: After reset the output enable `q_oe` and the loss flag `err` are both 0.
- R2: With `we_n` high when a column fall is detected, the bit at (row, column) appears on `q` with `q_oe`=1 once ACC_DLY cycles have passed after the detection cycle. Detection happens two clocks after the pin edge. The bit holds while `cas_n` stays low.
- R3: `q_oe` is 0 whenever `cas_n` is high, and it returns to 0 within three clocks of `cas_n` rising.
- R4: With `we_n` low before the column fall (early write), `din` is stored at that fall and `q_oe` stays 0 for the whole cycle.
- R5: A `we_n` fall while `cas_n` is low in an access cycle (late write or read-modify-write) stores `din`. `q_oe` and `q` keep following the read sequence, with the value that was read before the write.
- R6: `din` has no effect during a read cycle. A later read returns the earlier contents.
- R7: If `cas_n` is low when `ras_n` falls, the cycle only refreshes. The address bus, `we_n` and `din` are ignored, and the row comes from an internal counter that advances by one (mod the row count) on every such fall, including falls while `cas_n` stays low.
- R8: A row cycle with `cas_n` held high refreshes the addressed row and leaves `q_oe` at 0.
- R9: Keeping `cas_n` low after a valid read while `ras_n` rises and falls again (hidden refresh) keeps `q_oe`=1 and `q` unchanged until `cas_n` rises.
- R10: Each row has an age counter that any `ras_n` fall selecting that row resets. When any age reaches RET_LIMIT cycles, `err` goes to 1 and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| q | output | 1 | Read data bit, 0 when not enabled |
| q_oe | output | 1 | 1 when the data output is driven |
| err | output | 1 | Sticky retention-loss flag |

## Verification
The assertions assume the strobes are slow compared with the clock. Each level is held for at least three clocks, so each edge is detected once and the address and data beside it are sampled stably. They also assume that a cycle is never abandoned halfway through an access. The bench only changes pins just after a falling clock edge. It holds every strobe level for three or more clocks, sets up `we_n` and the address a full cycle before the strobe that uses them, and waits for the output to become valid before it starts any hidden refresh.

// File: rtl/async_dram_emu.sv
module async_dram_emu #(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int ACC_DLY   = 3,
  parameter int RET_LIMIT = 4000,
  parameter int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              q,
  output logic              q_oe,
  output logic              err
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;
  localparam int CW   = $clog2(ACC_DLY + 1);
  localparam int TW   = $clog2(RET_LIMIT + 1);

  logic s_ras, p_ras, s_cas, p_cas, s_we, p_we, s_din;
  logic [ADDR_W-1:0] s_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s_ras, p_ras, s_cas, p_cas, s_we, p_we} <= '1;
      s_din  <= 1'b0;
      s_addr <= '0;
    end else begin
      s_ras <= ras_n;  p_ras <= s_ras;
      s_cas <= cas_n;  p_cas <= s_cas;
      s_we  <= we_n;   p_we  <= s_we;
      s_din <= din;    s_addr <= addr;
    end
  end

  wire ras_fall = p_ras & ~s_ras;
  wire ras_rise = ~p_ras & s_ras;
  wire cas_fall = p_cas & ~s_cas;
  wire cas_rise = ~p_cas & s_cas;
  wire we_fall  = p_we & ~s_we;

  logic             active, cbr, early, colv, qv, qd;
  logic [ROW_W-1:0] row, rfc;
  logic [COL_W-1:0] col;
  logic [CW-1:0]    cnt;
  logic [COLS-1:0]  mem [ROWS];

  wire [ROW_W-1:0] ref_row = s_cas ? s_addr[ROW_W-1:0] : rfc;
  wire col_go  = cas_fall & active & ~cbr;
  wire wr_erly = col_go & ~s_we;
  wire wr_late = we_fall & colv & ~early & ~s_cas;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {active, cbr, early, colv, qv, qd} <= '0;
      row <= '0; rfc <= '0; col <= '0; cnt <= '0;
    end else begin
      if (ras_fall) begin
        active <= 1'b1;
        cbr    <= ~s_cas;
        row    <= ref_row;
        if (!s_cas) rfc <= rfc + 1'b1;
      end
      if (ras_rise) begin
        active <= 1'b0; cbr <= 1'b0; colv <= 1'b0; early <= 1'b0;
      end
      if (col_go) begin
        col   <= s_addr[COL_W-1:0];
        colv  <= 1'b1;
        early <= ~s_we;
        if (s_we) cnt <= CW'(ACC_DLY);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          qv <= 1'b1;
          qd <= mem[row][col];
        end
      end
      if (cas_rise) begin
        qv <= 1'b0; cnt <= '0; colv <= 1'b0; early <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_erly) mem[row][s_addr[COL_W-1:0]] <= s_din;
    else if (wr_late) mem[row][col] <= s_din;
  end

  logic [TW-1:0] age [ROWS];
  logic          expired;

  always_comb begin
    expired = 1'b0;
    for (int r = 0; r < ROWS; r++)
      if (age[r] == TW'(RET_LIMIT)) expired = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) age[r] <= '0;
      err <= 1'b0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (ras_fall && ref_row == ROW_W'(r)) age[r] <= '0;
        else if (age[r] != TW'(RET_LIMIT)) age[r] <= age[r] + 1'b1;
      end
      if (expired) err <= 1'b1;
    end
  end

  assign q_oe = qv;
  assign q    = qv & qd;

  p_hiz_cas_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cas && p_cas) |-> !q_oe);
  p_early_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    early |-> !q_oe);
  p_valid_under_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |-> (!s_cas && !p_cas && !early));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: tb/async_dram_emu_tb.sv
module async_dram_emu_tb;
  localparam int ACC = 3;
  localparam int LIM = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [3:0] addr = '0;
  logic q, q_oe, err;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit exp_q[$];
  string tag_q[$];
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;

  async_dram_emu #(.ROW_W(4), .COL_W(4), .ACC_DLY(ACC), .RET_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .q(q), .q_oe(q_oe), .err(err));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && q_oe && !prev_oe) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected output", 1, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(q == e, t, q, e);
      end
    end
    prev_oe = q_oe;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_early(input int r, input int c, input bit d);
    addr = 4'(r); ras_n = 1'b0; idle(3);
    addr = 4'(c); we_n = 1'b0; din = d; idle(1);
    cas_n = 1'b0; idle(3);
    check(!q_oe, "R4 early write off", q_oe, 0);
    idle(ACC + 3);
    check(!q_oe, "R4 early write stays off", q_oe, 0);
    cas_n = 1'b1; we_n = 1'b1; idle(3);
    ras_n = 1'b1; idle(3);
  endtask

  task automatic rd(input int r, input int c, input bit e, input string t);
    addr = 4'(r); ras_n = 1'b0; idle(3);
    addr = 4'(c); we_n = 1'b1; din = ~e; cas_n = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    idle(2);
    check(!q_oe, "R2 not valid before delay", q_oe, 0);
    idle(ACC + 3);
    check(q_oe, "R2 valid while cas low", q_oe, 1);
    cas_n = 1'b1; idle(3);
    check(!q_oe, "R3 off after cas rise", q_oe, 0);
    ras_n = 1'b1; idle(3);
  endtask

  task automatic wr_late(input int r, input int c, input bit d, input bit old);
    addr = 4'(r); ras_n = 1'b0; idle(3);
    addr = 4'(c); we_n = 1'b1; cas_n = 1'b0;
    exp_q.push_back(old); tag_q.push_back("R5 read part of rmw");
    idle(ACC + 5);
    din = d; we_n = 1'b0; idle(4);
    check(q_oe && q == old, "R5 output holds read value", q, old);
    we_n = 1'b1; cas_n = 1'b1; idle(3);
    ras_n = 1'b1; idle(3);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check(!q_oe, "R1 reset oe", q_oe, 0);
    check(!err, "R1 reset err", err, 0);

    wr_early(1, 2, 1);
    wr_early(1, 3, 0);
    wr_early(7, 2, 1);
    wr_early(15, 15, 1);
    wr_early(0, 0, 0);

    rd(1, 2, 1, "R2 read 1,2");
    rd(1, 3, 0, "R2 read 1,3");
    rd(7, 2, 1, "R6 read with din opposite");
    rd(7, 2, 1, "R6 contents unchanged");
    rd(0, 0, 0, "R2 read 0,0");

    wr_late(1, 3, 1, 0);
    rd(1, 3, 1, "R5 late write stored");

    // R7: refresh-only cycle ignores address, we_n and din
    addr = 4'd1; din = 1'b0; we_n = 1'b0; cas_n = 1'b0; idle(3);
    ras_n = 1'b0; idle(4);
    check(!q_oe, "R7 no output in refresh", q_oe, 0);
    ras_n = 1'b1; idle(3);
    cas_n = 1'b1; we_n = 1'b1; idle(3);
    rd(1, 2, 1, "R7 row1 col2 intact");
    rd(1, 3, 1, "R7 row1 col3 intact");

    // R8: row-only refresh
    addr = 4'd7; ras_n = 1'b0; idle(6);
    check(!q_oe, "R8 row-only refresh off", q_oe, 0);
    ras_n = 1'b1; idle(3);
    rd(7, 2, 1, "R8 data kept");

    // R9: hidden refresh
    addr = 4'd15; ras_n = 1'b0; idle(3);
    addr = 4'd15; cas_n = 1'b0;
    exp_q.push_back(1'b1); tag_q.push_back("R9 first read");
    idle(ACC + 4);
    ras_n = 1'b1; idle(3);
    addr = 4'd0; ras_n = 1'b0; idle(4);
    check(q_oe && q == 1'b1, "R9 output kept during refresh", q, 1);
    ras_n = 1'b1; idle(3);
    check(q_oe && q == 1'b1, "R9 output kept after refresh", q, 1);
    cas_n = 1'b1; idle(3);
    check(!q_oe, "R3 off after hidden refresh", q_oe, 0);

    // R10 and R7 counter: rows left alone for a long stretch
    idle(2500);
    check(!err, "R10 no loss yet", err, 0);
    cas_n = 1'b0; idle(3);
    for (int i = 0; i < 16; i++) begin
      ras_n = 1'b0; idle(3);
      ras_n = 1'b1; idle(3);
    end
    cas_n = 1'b1; idle(3);
    idle(3000);
    check(!err, "R7 counter burst refreshed every row", err, 0);
    idle(1500);
    check(err, "R10 loss flagged", err, 1);
    rd(15, 15, 1, "R10 read after loss");
    check(err, "R10 flag sticky", err, 1);

    check(exp_q.size() == 0, "R2 all reads observed", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      check(1'b0, "watchdog expired", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule